// File: doc/BRIEF.md
# SPI Flash Access Guard

This block sits inside an SPI flash host controller and rules on each flash cycle before it is issued. It keeps a protected-region floor and a set of approved prefix opcodes. A request carries a 24-bit flash address, an opcode and a flag that marks the first command of an atomic sequence. One clock later the guard answers with allow or deny. Every denial also sets a violation flag that stays set until software clears it.

Software programs the guard through a small word-wide register port. Writes to the floor register and the prefix register take effect until software sets a lock bit. From then on both registers are frozen until the next reset. The floor holds only the upper 16 address bits. The low 8 bits count as zero. The guard does not know the flash size, so it compares the field exactly as software wrote it.

Top module: `spi_access_guard`

## Requirements
- R1: After reset, register 0 (floor) reads 0x00000000, register 1 (prefix) reads 0x00000004, register 2 (control) reads 0x00000000, and dec_valid, dec_allow, dec_deny and viol_flag are all low.
- R2: A request whose address is below {floor,8'h00} is denied. A request whose address is at or above that value passes the floor check.
- R3: With the floor field at 0000h, every address passes the floor check, including 0x000000 and 0x000001.
- R4: The floor comparison uses all 16 field bits exactly as programmed, including upper bits set to 1. For example, a floor of FFFFh denies 0xFFFEFF and allows 0xFFFF00.
- R5: A request with req_atomic_first=1 passes only if its opcode equals prefix 1 (register 1 bits 15:8) or prefix 2 (register 1 bits 7:0). When req_atomic_first=0 the prefix values have no effect.
- R6: Register 0 holds the floor in bits 23:8. Bits 31:24 and 7:0 read as zero, and writes to them have no effect. Register 1 holds both prefixes in bits 15:0, and its upper bits read as zero.
- R7: Writing 1 to register 2 bit 0 sets the lock. Writing 0 there leaves it unchanged. Only reset clears it.
- R8: While the lock is set, writes to register 0 and register 1 are ignored.
- R9: When req_valid is sampled high at a clock edge, dec_valid is high for the following cycle, with exactly one of dec_allow and dec_deny high. When req_valid is sampled low, all three outputs are low in the following cycle.
- R10: The violation flag (viol_flag, also register 2 bit 1) sets in the cycle dec_deny is high and then stays set. Writing 1 to register 2 bit 1 clears it. If a denial and a clear land at the same edge, the denial wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for both write and read (0 floor, 1 prefix, 2 control) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| req_valid | input | 1 | Flash cycle request strobe |
| req_addr | input | 24 | Flash address of the request |
| req_opcode | input | 8 | Opcode of the request |
| req_atomic_first | input | 1 | Request is the first command of an atomic sequence |
| dec_valid | output | 1 | Decision valid, one cycle after the request |
| dec_allow | output | 1 | Request allowed |
| dec_deny | output | 1 | Request denied (one-cycle pulse per request) |
| viol_flag | output | 1 | Sticky violation flag |

## Verification
The assertions assume that reg_sel, reg_wr and the request fields are stable and known at each clock edge. They also assume that a register write and a request may coincide, with the request judged against the register values from before that edge. The stimulus changes inputs only just after a rising edge. It deliberately includes writes that land in the same cycle as requests, including a violation clear in the same cycle as a denial. Floors with upper bits set to 1, and addresses just below and at the floor, are covered both by directed cases and by a long mixed random phase.

// File: rtl/spi_guard_pkg.sv
package spi_guard_pkg;

   localparam int REG_SEL_W = 2;

   typedef enum logic [REG_SEL_W-1:0] {
      SEL_FLOOR  = 2'd0,
      SEL_PREFIX = 2'd1,
      SEL_CTRL   = 2'd2,
      SEL_SPARE  = 2'd3
   } reg_sel_e;

   localparam int CTRL_LOCK_BIT = 0;
   localparam int CTRL_VIOL_BIT = 1;

   typedef struct packed {
      logic valid;
      logic allow;
      logic deny;
   } verdict_t;

endpackage

// File: rtl/guard_floor_cmp.sv
module guard_floor_cmp #(
   parameter int ADDR_W    = 24,
   parameter int FLOOR_LSB = 8,
   localparam int FLOOR_W  = ADDR_W - FLOOR_LSB
) (
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [FLOOR_W-1:0] floor_i,
   output logic               pass_o
);

   if (FLOOR_LSB < 1 || FLOOR_LSB >= ADDR_W) begin : g_bad_lsb
      $error("guard_floor_cmp: FLOOR_LSB must lie inside the address");
   end

   // The low FLOOR_LSB bits of the floor count as zero, so comparing
   // only the upper slice is exact: addr >= {floor, 0...0}.
   logic [FLOOR_W-1:0] addr_hi;
   logic               unused_low_bits;

   assign addr_hi         = addr_i[ADDR_W-1:FLOOR_LSB];
   assign unused_low_bits = ^addr_i[FLOOR_LSB-1:0];
   assign pass_o          = (addr_hi >= floor_i);

endmodule

// File: rtl/guard_prefix_match.sv
module guard_prefix_match #(
   parameter int OP_W     = 8,
   parameter int N_PREFIX = 2
) (
   input  logic [OP_W-1:0]          opcode_i,
   input  logic [N_PREFIX*OP_W-1:0] prefix_i,
   output logic                     hit_o
);

   if (N_PREFIX < 1) begin : g_bad_count
      $error("guard_prefix_match: need at least one prefix slot");
   end

   logic [N_PREFIX-1:0] slot_hit;

   for (genvar k = 0; k < N_PREFIX; k++) begin : g_slot
      assign slot_hit[k] = (opcode_i == prefix_i[k*OP_W +: OP_W]);
   end

   assign hit_o = |slot_hit;

endmodule

// File: rtl/guard_regs.sv
module guard_regs
   import spi_guard_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int FLOOR_LSB = 8,
   parameter int OP_W      = 8,
   parameter int N_PREFIX  = 2,
   parameter int DATA_W    = 32,
   parameter logic [N_PREFIX*OP_W-1:0] PREFIX_RST = 16'h0004,
   localparam int FLOOR_W  = ADDR_W - FLOOR_LSB,
   localparam int PFX_W    = N_PREFIX * OP_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  reg_sel_e             sel,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic                 deny_evt,
   output logic [DATA_W-1:0]    rd_data,
   output logic [FLOOR_W-1:0]   floor_o,
   output logic [PFX_W-1:0]     prefix_o,
   output logic                 lock_o,
   output logic                 viol_o
);

   if (ADDR_W > DATA_W) begin : g_bad_addr
      $error("guard_regs: address does not fit in a register word");
   end
   if (PFX_W > DATA_W) begin : g_bad_pfx
      $error("guard_regs: prefix set does not fit in a register word");
   end
   if (DATA_W < 2) begin : g_bad_ctrl
      $error("guard_regs: control register needs two bits");
   end

   logic [FLOOR_W-1:0] floor_q;
   logic [PFX_W-1:0]   prefix_q;
   logic               lock_q;
   logic               viol_q;
   logic               wr_floor, wr_prefix, wr_ctrl;
   logic               unused_wbits;

   assign wr_floor     = wr_en && (sel == SEL_FLOOR)  && !lock_q;
   assign wr_prefix    = wr_en && (sel == SEL_PREFIX) && !lock_q;
   assign wr_ctrl      = wr_en && (sel == SEL_CTRL);
   assign unused_wbits = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         floor_q  <= '0;
         prefix_q <= PREFIX_RST;
      end else begin
         if (wr_floor)  floor_q  <= wr_data[ADDR_W-1:FLOOR_LSB];
         if (wr_prefix) prefix_q <= wr_data[PFX_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
      end else if (wr_ctrl && wr_data[CTRL_LOCK_BIT]) begin
         lock_q <= 1'b1;
      end
   end

   // Set has priority over the write-one-to-clear.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         viol_q <= 1'b0;
      end else if (deny_evt) begin
         viol_q <= 1'b1;
      end else if (wr_ctrl && wr_data[CTRL_VIOL_BIT]) begin
         viol_q <= 1'b0;
      end
   end

   always_comb begin
      rd_data = '0;
      unique case (sel)
         SEL_FLOOR:  rd_data[ADDR_W-1:FLOOR_LSB] = floor_q;
         SEL_PREFIX: rd_data[PFX_W-1:0]          = prefix_q;
         SEL_CTRL: begin
            rd_data[CTRL_LOCK_BIT] = lock_q;
            rd_data[CTRL_VIOL_BIT] = viol_q;
         end
         default:    rd_data = '0;
      endcase
   end

   assign floor_o  = floor_q;
   assign prefix_o = prefix_q;
   assign lock_o   = lock_q;
   assign viol_o   = viol_q;

   a_r7_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q)
      else $error("lock bit dropped without reset");

   a_r8_floor_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> $stable(floor_q))
      else $error("floor changed while locked");

   a_r8_prefix_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> $stable(prefix_q))
      else $error("prefix changed while locked");

   a_r10_viol_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_q && !(wr_en && sel == SEL_CTRL && wr_data[CTRL_VIOL_BIT])) |=> viol_q)
      else $error("violation flag cleared without a clear write");

endmodule

// File: rtl/spi_access_guard.sv
module spi_access_guard
   import spi_guard_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int FLOOR_LSB = 8,
   parameter int OP_W      = 8,
   parameter int N_PREFIX  = 2,
   parameter int DATA_W    = 32,
   parameter logic [N_PREFIX*OP_W-1:0] PREFIX_RST = 16'h0004,
   localparam int FLOOR_W  = ADDR_W - FLOOR_LSB,
   localparam int PFX_W    = N_PREFIX * OP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [OP_W-1:0]   req_opcode,
   input  logic              req_atomic_first,
   output logic              dec_valid,
   output logic              dec_allow,
   output logic              dec_deny,
   output logic              viol_flag
);

   logic [FLOOR_W-1:0] floor_w;
   logic [PFX_W-1:0]   prefix_w;
   logic               lock_w;
   logic               floor_pass;
   logic               prefix_hit;
   logic               req_ok;
   logic               deny_now;
   verdict_t           verdict_q;

   guard_regs #(
      .ADDR_W     (ADDR_W),
      .FLOOR_LSB  (FLOOR_LSB),
      .OP_W       (OP_W),
      .N_PREFIX   (N_PREFIX),
      .DATA_W     (DATA_W),
      .PREFIX_RST (PREFIX_RST)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr),
      .sel      (reg_sel_e'(reg_sel)),
      .wr_data  (reg_wdata),
      .deny_evt (deny_now),
      .rd_data  (reg_rdata),
      .floor_o  (floor_w),
      .prefix_o (prefix_w),
      .lock_o   (lock_w),
      .viol_o   (viol_flag)
   );

   guard_floor_cmp #(
      .ADDR_W    (ADDR_W),
      .FLOOR_LSB (FLOOR_LSB)
   ) u_floor (
      .addr_i  (req_addr),
      .floor_i (floor_w),
      .pass_o  (floor_pass)
   );

   guard_prefix_match #(
      .OP_W     (OP_W),
      .N_PREFIX (N_PREFIX)
   ) u_prefix (
      .opcode_i (req_opcode),
      .prefix_i (prefix_w),
      .hit_o    (prefix_hit)
   );

   assign req_ok   = floor_pass && (!req_atomic_first || prefix_hit);
   assign deny_now = req_valid && !req_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         verdict_q <= '0;
      end else begin
         verdict_q.valid <= req_valid;
         verdict_q.allow <= req_valid && req_ok;
         verdict_q.deny  <= deny_now;
      end
   end

   assign dec_valid = verdict_q.valid;
   assign dec_allow = verdict_q.allow;
   assign dec_deny  = verdict_q.deny;

   logic unused_lock;
   assign unused_lock = lock_w;

   a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> dec_valid)
      else $error("no decision one cycle after request");

   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!dec_valid && !dec_allow && !dec_deny))
      else $error("decision outputs active without request");

   a_r9_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> (dec_allow ^ dec_deny))
      else $error("decision not exactly one of allow and deny");

   a_r3_zero_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && floor_w == '0 && !req_atomic_first) |=> dec_allow)
      else $error("zero floor refused a plain request");

   a_r10_viol_on_deny: assert property (@(posedge clk) disable iff (!rst_n)
      dec_deny |-> viol_flag)
      else $error("denial did not set the violation flag");

endmodule

// File: tb/sim_spi_access_guard.sv
`timescale 1ns/1ps
module sim_spi_access_guard;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        req_valid = 1'b0;
   logic [23:0] req_addr = '0;
   logic [7:0]  req_opcode = '0;
   logic        req_atomic_first = 1'b0;
   logic        dec_valid, dec_allow, dec_deny, viol_flag;

   always #2 clk = ~clk;

   spi_access_guard u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
      .req_addr(req_addr), .req_opcode(req_opcode),
      .req_atomic_first(req_atomic_first), .dec_valid(dec_valid),
      .dec_allow(dec_allow), .dec_deny(dec_deny), .viol_flag(viol_flag)
   );

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   // behavioural model state
   int m_floor, m_prefix, m_lock, m_viol;
   int e_valid, e_allow, e_deny;

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(input int sel);
      case (sel)
         0: return 32'(m_floor) << 8;
         1: return 32'(m_prefix);
         2: return 32'((m_viol << 1) | m_lock);
         default: return 32'h0;
      endcase
   endfunction

   task automatic model_reset();
      m_floor = 0; m_prefix = 'h0004; m_lock = 0; m_viol = 0;
      e_valid = 0; e_allow = 0; e_deny = 0;
   endtask

   task automatic do_reset();
      req_valid = 0; reg_wr = 0;
      rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      model_reset();
   endtask

   // One clock: drive, model the edge, then compare every output.
   task automatic cyc(input bit rv, input logic [23:0] ra, input logic [7:0] op,
                      input bit af, input bit wr, input int sel,
                      input logic [31:0] wd, input string tag);
      int ok, nviol;
      req_valid = rv; req_addr = ra; req_opcode = op; req_atomic_first = af;
      reg_wr = wr; reg_sel = 2'(sel); reg_wdata = wd;
      @(posedge clk);
      ok = ((ra >> 8) >= m_floor) &&
           (!af || op == 8'(m_prefix >> 8) || op == 8'(m_prefix)) ? 1 : 0;
      e_valid = rv ? 1 : 0;
      e_allow = (rv && ok) ? 1 : 0;
      e_deny  = (rv && !ok) ? 1 : 0;
      nviol = m_viol;
      if (wr && sel == 2 && wd[1]) nviol = 0;
      if (e_deny) nviol = 1;
      m_viol = nviol;
      if (wr && sel == 0 && !m_lock) m_floor = int'(wd[23:8]);
      if (wr && sel == 1 && !m_lock) m_prefix = int'(wd[15:0]);
      if (wr && sel == 2 && wd[0]) m_lock = 1;
      #1;
      chk(tag, "dec_valid", 32'(dec_valid), 32'(e_valid));
      chk(tag, "dec_allow", 32'(dec_allow), 32'(e_allow));
      chk(tag, "dec_deny",  32'(dec_deny),  32'(e_deny));
      chk("R10", "viol_flag", 32'(viol_flag), 32'(m_viol));
      chk(tag, "reg_rdata", reg_rdata, exp_read(sel));
   endtask

   task automatic rd(input int sel, input string tag);
      cyc(0, 24'h0, 8'h0, 0, 0, sel, 32'h0, tag);
   endtask

   task automatic wreg(input int sel, input logic [31:0] wd, input string tag);
      cyc(0, 24'h0, 8'h0, 0, 1, sel, wd, tag);
   endtask

   task automatic req(input logic [23:0] a, input logic [7:0] op, input bit af,
                      input string tag);
      cyc(1, a, op, af, 0, 2, 32'h0, tag);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL R9 watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      model_reset();
      do_reset();

      // R1: reset values, outputs idle
      #1;
      chk("R1", "reset dec_valid", 32'(dec_valid), 32'h0);
      chk("R1", "reset viol_flag", 32'(viol_flag), 32'h0);
      rd(0, "R1"); rd(1, "R1"); rd(2, "R1"); rd(3, "R1");

      // R3: zero floor passes every address
      req(24'h000000, 8'h9F, 0, "R3");
      req(24'h000001, 8'h9F, 0, "R3");
      req(24'hFFFFFF, 8'h03, 0, "R3");

      // R6: floor layout, outer bits ignored
      wreg(0, 32'hAB1234CD, "R6");
      rd(0, "R6");
      wreg(1, 32'hFFFF0004, "R6");
      rd(1, "R6");

      // R2: around the floor 0x123400
      req(24'h1233FF, 8'h03, 0, "R2");
      req(24'h123400, 8'h03, 0, "R2");
      req(24'h123401, 8'h03, 0, "R2");
      req(24'h000001, 8'h9F, 0, "R2");
      rd(2, "R10");
      // R10: clear, then deny and clear in the same edge
      wreg(2, 32'h2, "R10");
      rd(2, "R10");
      cyc(1, 24'h000010, 8'h03, 0, 1, 2, 32'h2, "R10");
      rd(2, "R10");
      wreg(2, 32'h2, "R10");

      // R4: all-ones floor
      wreg(0, 32'h00FFFF00, "R4");
      req(24'hFFFEFF, 8'h03, 0, "R4");
      req(24'hFFFF00, 8'h03, 0, "R4");
      req(24'hFFFFFF, 8'h03, 0, "R4");

      // R5: prefix whitelist
      wreg(0, 32'h0, "R5");
      req(24'h000100, 8'h04, 1, "R5");
      req(24'h000100, 8'h00, 1, "R5");
      req(24'h000100, 8'h06, 1, "R5");
      req(24'h000100, 8'h06, 0, "R5");
      wreg(1, 32'h00005006, "R5");
      req(24'h000100, 8'h50, 1, "R5");
      req(24'h000100, 8'h06, 1, "R5");
      req(24'h000100, 8'h04, 1, "R5");
      wreg(2, 32'h2, "R10");

      // R7 / R8: lock
      wreg(2, 32'h0, "R7");
      rd(2, "R7");
      wreg(0, 32'h00020000, "R8");
      wreg(2, 32'h1, "R7");
      wreg(0, 32'h00FF0000, "R8");
      wreg(1, 32'h0000AAAA, "R8");
      rd(0, "R8"); rd(1, "R8");
      wreg(2, 32'h0, "R7");
      rd(2, "R7");
      req(24'h01FFFF, 8'h03, 0, "R8");
      req(24'h020000, 8'h50, 1, "R8");
      req(24'h020000, 8'hAA, 1, "R8");

      // R7: only reset clears the lock
      do_reset();
      rd(2, "R7");
      rd(1, "R1");

      // R9: mixed random traffic against the model
      for (int i = 0; i < 600; i++) begin
         logic [31:0] r1, r2, r3;
         int sel;
         r1 = $urandom; r2 = $urandom; r3 = $urandom;
         sel = int'(r3[1:0]);
         if (sel == 2 && r3[7:4] != 0) r2[0] = 1'b0;
         cyc(r3[8], r1[23:0], r3[2] ? 8'(r1[31:24] & 8'h07) : r1[31:24],
             r3[9], r3[10] & r3[11], sel, r2, "R9");
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule